// File: doc/BRIEF.md
# ADC Calibration Sequence Controller

This block steps a sigma-delta converter through its calibration routines. Software selects a routine by writing a 3-bit operation-mode field. The block waits for the next conversion-cycle boundary, which arrives as a one-cycle `conv_tick` strobe. It then runs the routine, counting boundaries, and returns by itself to normal operation. It steers the sampling front end to one of three sources: the analog input, the shorted inputs, or the reference. It pulses one-cycle capture strobes so that an external datapath can latch its offset or full-scale coefficient.

The data-ready output `drdy_n` is active low. In normal operation it follows the datapath's data-valid flag. From the boundary that starts a routine until the filter has been refilled afterwards, it is held high. When a routine finishes, the block clears the mode field to normal. While a routine runs, mode writes are ignored.

Top module: `adc_cal_sequencer`

## Requirements
- R1: After synchronous reset, `mode_q` is 000, `front_sel` is 0 (analog input), both capture strobes are low, and `drdy_n` is the inverse of `data_valid`.
- R2: A mode write stores `mode_wdata` into `mode_q` on the next edge. A calibration code (001 self, 010 system offset, 011 system full-scale) starts its routine only at the first `conv_tick` seen while `mode_q` already holds that code. A write that lands in the same cycle as a tick, while `mode_q` is normal, starts nothing until a later tick.
- R3: From the start tick until the routine, including its refill conversions, has finished, `drdy_n` stays 1 whatever the value of `data_valid`.
- R4: In self-calibration, `front_sel` is 1 (shorted inputs) for the offset phase. That phase lasts 3 boundaries, or 4 when `slave_mode` was high at the start tick. `offset_capture` pulses in the cycle of the phase's last tick.
- R5: In self-calibration, the next phase has `front_sel` at 2 (reference) for 3 boundaries. `fullscale_capture` pulses in the cycle of its last tick.
- R6: After the self-calibration full-scale phase, `mode_q` reads 000 and `front_sel` is 0. Three further boundaries pass with `drdy_n` high. After the third boundary, `drdy_n` again follows `data_valid`.
- R7: Code 010 runs an offset phase, and code 011 runs a full-scale phase, on the analog input (`front_sel` 0). Each lasts 3 boundaries, or 4 with slave mode latched. The matching capture strobe pulses on the last tick.
- R8: After a system offset or system full-scale phase, `mode_q` reads 000. Exactly one further boundary passes with `drdy_n` high; after it, `drdy_n` follows `data_valid`.
- R9: Mode writes are ignored from the start tick (inclusive) until the routine ends. `mode_q` keeps the running code until the block clears it.
- R10: Codes 100 to 111 are stored and read back but act as normal mode: a tick starts nothing, `front_sel` stays 0 and `drdy_n` follows `data_valid`.
- R11: In normal mode, `drdy_n` equals the inverse of `data_valid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_tick | input | 1 | One-cycle strobe at each conversion-cycle boundary |
| mode_wr | input | 1 | Write enable for the mode field |
| mode_wdata | input | 3 | Mode code to write |
| slave_mode | input | 1 | Slave operation; adds one offset boundary (latched at start) |
| data_valid | input | 1 | Normal data-valid flag from the datapath |
| mode_q | output | 3 | Current mode field |
| front_sel | output | 2 | Front-end select: 0 input, 1 shorted, 2 reference |
| offset_capture | output | 1 | Strobe: latch the offset coefficient |
| fullscale_capture | output | 1 | Strobe: latch the full-scale coefficient |
| drdy_n | output | 1 | Data ready, active low |

## Verification
A mode write and a conversion boundary can fall in the same cycle. The result depends on whether the registered field already holds a calibration code. With a code pending, the tick starts that routine and the simultaneous write must be dropped, so `mode_q` keeps the old code and the old routine's phase lengths are observed. With the field at normal, the same collision stores the new code but must not start it; `drdy_n` must stay low until the following tick. The bench drives `mode_wr` and `conv_tick` together at one falling edge for both cases and judges the readback, `drdy_n` and the cycle of the capture strobe.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_SELF_OFS = 3'd1,
        PH_SELF_FS  = 3'd2,
        PH_SYS_OFS  = 3'd3,
        PH_SYS_FS   = 3'd4,
        PH_REFILL   = 3'd5
    } cal_phase_e;

    typedef enum logic [1:0] {
        SEL_INPUT = 2'd0,
        SEL_SHORT = 2'd1,
        SEL_REF   = 2'd2
    } front_sel_e;

    localparam logic [2:0] MODE_NORMAL  = 3'b000;
    localparam logic [2:0] MODE_SELF    = 3'b001;
    localparam logic [2:0] MODE_SYS_OFS = 3'b010;
    localparam logic [2:0] MODE_SYS_FS  = 3'b011;

    typedef struct packed {
        logic restart;
        logic ofs_cap;
        logic fs_cap;
        logic clr_mode;
    } fsm_evt_t;

    function automatic logic is_cal_code(input logic [2:0] m);
        return (m == MODE_SELF) || (m == MODE_SYS_OFS) || (m == MODE_SYS_FS);
    endfunction

    function automatic front_sel_e sel_for_phase(input cal_phase_e p);
        case (p)
            PH_SELF_OFS: return SEL_SHORT;
            PH_SELF_FS:  return SEL_REF;
            default:     return SEL_INPUT;
        endcase
    endfunction

endpackage

// File: rtl/cal_mode_reg.sv
module cal_mode_reg #(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    input  logic              accept,
    input  logic              clear,
    output logic [MODE_W-1:0] mode_q
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            mode_q <= '0;
        end else if (wr_en && accept) begin
            mode_q <= wr_data;
        end
    end
endmodule

// File: rtl/cal_cycle_counter.sv
module cal_cycle_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = tick && (cnt == limit - 1'b1);
endmodule

// File: rtl/cal_phase_fsm.sv
module cal_phase_fsm
    import adc_cal_pkg::*;
#(
    parameter int OFS_CYCLES  = 3,
    parameter int FS_CYCLES   = 3,
    parameter int SLAVE_EXTRA = 1,
    parameter int SELF_REFILL = 3,
    parameter int SYS_REFILL  = 1,
    parameter int CNT_W       = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [2:0]       mode_q,
    input  logic             slave_in,
    input  logic             last,
    output cal_phase_e       phase,
    output logic [CNT_W-1:0] limit,
    output fsm_evt_t         evt
);
    localparam logic [CNT_W-1:0] OFS_LEN    = CNT_W'(OFS_CYCLES);
    localparam logic [CNT_W-1:0] OFS_LEN_SL = CNT_W'(OFS_CYCLES + SLAVE_EXTRA);
    localparam logic [CNT_W-1:0] FS_LEN     = CNT_W'(FS_CYCLES);
    localparam logic [CNT_W-1:0] SELF_RF    = CNT_W'(SELF_REFILL);
    localparam logic [CNT_W-1:0] SYS_RF     = CNT_W'(SYS_REFILL);

    cal_phase_e       phase_nx;
    logic             slave_q, slave_nx;
    logic [CNT_W-1:0] refill_q, refill_nx;
    logic [CNT_W-1:0] sys_len;

    assign sys_len = slave_q ? OFS_LEN_SL : OFS_LEN;

    always_comb begin
        case (phase)
            PH_SELF_OFS,
            PH_SYS_OFS,
            PH_SYS_FS:  limit = sys_len;
            PH_SELF_FS: limit = FS_LEN;
            PH_REFILL:  limit = refill_q;
            default:    limit = OFS_LEN;
        endcase
    end

    always_comb begin
        phase_nx  = phase;
        slave_nx  = slave_q;
        refill_nx = refill_q;
        evt       = '0;
        case (phase)
            PH_IDLE: begin
                if (tick && is_cal_code(mode_q)) begin
                    evt.restart = 1'b1;
                    slave_nx    = slave_in;
                    case (mode_q)
                        MODE_SELF:    phase_nx = PH_SELF_OFS;
                        MODE_SYS_OFS: phase_nx = PH_SYS_OFS;
                        default:      phase_nx = PH_SYS_FS;
                    endcase
                end
            end
            PH_SELF_OFS: begin
                if (last) begin
                    evt.restart = 1'b1;
                    evt.ofs_cap = 1'b1;
                    phase_nx    = PH_SELF_FS;
                end
            end
            PH_SELF_FS: begin
                if (last) begin
                    evt.restart  = 1'b1;
                    evt.fs_cap   = 1'b1;
                    evt.clr_mode = 1'b1;
                    refill_nx    = SELF_RF;
                    phase_nx     = PH_REFILL;
                end
            end
            PH_SYS_OFS,
            PH_SYS_FS: begin
                if (last) begin
                    evt.restart  = 1'b1;
                    evt.ofs_cap  = (phase == PH_SYS_OFS);
                    evt.fs_cap   = (phase == PH_SYS_FS);
                    evt.clr_mode = 1'b1;
                    refill_nx    = SYS_RF;
                    phase_nx     = PH_REFILL;
                end
            end
            PH_REFILL: begin
                if (last) begin
                    evt.restart = 1'b1;
                    phase_nx    = PH_IDLE;
                end
            end
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            slave_q  <= 1'b0;
            refill_q <= SYS_RF;
        end else begin
            phase    <= phase_nx;
            slave_q  <= slave_nx;
            refill_q <= refill_nx;
        end
    end
endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
    import adc_cal_pkg::*;
#(
    parameter int OFS_CYCLES  = 3,
    parameter int FS_CYCLES   = 3,
    parameter int SLAVE_EXTRA = 1,
    parameter int SELF_REFILL = 3,
    parameter int SYS_REFILL  = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       conv_tick,
    input  logic       mode_wr,
    input  logic [2:0] mode_wdata,
    input  logic       slave_mode,
    input  logic       data_valid,
    output logic [2:0] mode_q,
    output logic [1:0] front_sel,
    output logic       offset_capture,
    output logic       fullscale_capture,
    output logic       drdy_n
);
    localparam int MAX_A   = (OFS_CYCLES + SLAVE_EXTRA > FS_CYCLES) ? OFS_CYCLES + SLAVE_EXTRA : FS_CYCLES;
    localparam int MAX_B   = (SELF_REFILL > SYS_REFILL) ? SELF_REFILL : SYS_REFILL;
    localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    cal_phase_e       phase;
    fsm_evt_t         evt;
    logic [CNT_W-1:0] limit;
    logic             last;
    logic             seq_busy;
    logic             mode_clr;
    logic             wr_accept;

    assign seq_busy  = (phase != PH_IDLE);
    assign mode_clr  = evt.clr_mode;
    assign wr_accept = !seq_busy && !(conv_tick && is_cal_code(mode_q));

    cal_mode_reg #(.MODE_W(3)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mode_wr),
        .wr_data (mode_wdata),
        .accept  (wr_accept),
        .clear   (mode_clr),
        .mode_q  (mode_q)
    );

    cal_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .restart (evt.restart),
        .tick    (conv_tick),
        .limit   (limit),
        .last    (last)
    );

    cal_phase_fsm #(
        .OFS_CYCLES  (OFS_CYCLES),
        .FS_CYCLES   (FS_CYCLES),
        .SLAVE_EXTRA (SLAVE_EXTRA),
        .SELF_REFILL (SELF_REFILL),
        .SYS_REFILL  (SYS_REFILL),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick     (conv_tick),
        .mode_q   (mode_q),
        .slave_in (slave_mode),
        .last     (last),
        .phase    (phase),
        .limit    (limit),
        .evt      (evt)
    );

    assign front_sel         = sel_for_phase(phase);
    assign offset_capture    = evt.ofs_cap;
    assign fullscale_capture = evt.fs_cap;
    assign drdy_n            = seq_busy || !data_valid;
endmodule

// File: rtl/adc_cal_checker.sv
module adc_cal_checker (
    input logic       clk,
    input logic       rst,
    input logic       conv_tick,
    input logic       mode_wr,
    input logic [2:0] mode_q,
    input logic [1:0] front_sel,
    input logic       offset_capture,
    input logic       fullscale_capture,
    input logic       drdy_n,
    input logic       seq_busy,
    input logic       mode_clr
);
    // R3: a capture strobe only occurs inside a routine, where data-ready is held high
    p_drdy_held_r3: assert property (@(posedge clk) disable iff (rst)
        (offset_capture || fullscale_capture) |-> drdy_n);

    // R4, R5: strobes are never simultaneous and only fall on a boundary
    p_cap_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        !(offset_capture && fullscale_capture));
    p_cap_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        (offset_capture || fullscale_capture) |-> conv_tick);

    // R4: shorted inputs only while the self-calibration code is held
    p_short_self_r4: assert property (@(posedge clk) disable iff (rst)
        (front_sel == 2'd1) |-> (mode_q == 3'b001));

    // R6, R8: the field reads normal after the final calibration strobe
    p_mode_cleared_r8: assert property (@(posedge clk) disable iff (rst)
        mode_clr |=> (mode_q == 3'b000));

    // R9: writes during a routine leave the field untouched
    p_write_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (seq_busy && mode_wr && !mode_clr) |=> $stable(mode_q));

    // R2: a routine only starts on a boundary
    p_start_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_busy) |-> $past(conv_tick));
endmodule

bind adc_cal_sequencer adc_cal_checker u_chk (
    .clk               (clk),
    .rst               (rst),
    .conv_tick         (conv_tick),
    .mode_wr           (mode_wr),
    .mode_q            (mode_q),
    .front_sel         (front_sel),
    .offset_capture    (offset_capture),
    .fullscale_capture (fullscale_capture),
    .drdy_n            (drdy_n),
    .seq_busy          (seq_busy),
    .mode_clr          (mode_clr)
);

// File: tb/test_adc_cal_sequencer.sv
module test_adc_cal_sequencer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       conv_tick = 1'b0;
    logic       mode_wr = 1'b0;
    logic [2:0] mode_wdata = 3'b000;
    logic       slave_mode = 1'b0;
    logic       data_valid = 1'b1;
    logic [2:0] mode_q;
    logic [1:0] front_sel;
    logic       offset_capture;
    logic       fullscale_capture;
    logic       drdy_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    adc_cal_sequencer i_adc_cal_sequencer (
        .clk(clk), .rst(rst), .conv_tick(conv_tick), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .slave_mode(slave_mode), .data_valid(data_valid),
        .mode_q(mode_q), .front_sel(front_sel), .offset_capture(offset_capture),
        .fullscale_capture(fullscale_capture), .drdy_n(drdy_n)
    );

    // {mode[2:0], slave, n_ofs[2:0], n_fs[2:0], n_refill[2:0]}
    localparam logic [12:0] VECS [6] = '{
        {3'b001, 1'b0, 3'd3, 3'd3, 3'd3},
        {3'b001, 1'b1, 3'd4, 3'd3, 3'd3},
        {3'b010, 1'b0, 3'd3, 3'd0, 3'd1},
        {3'b010, 1'b1, 3'd4, 3'd0, 3'd1},
        {3'b011, 1'b0, 3'd0, 3'd3, 3'd1},
        {3'b011, 1'b1, 3'd0, 3'd4, 3'd1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] code);
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = code;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic do_tick(output logic oc, output logic fc);
        @(negedge clk);
        conv_tick = 1'b1;
        #1;
        oc = offset_capture; fc = fullscale_capture;
        @(negedge clk);
        conv_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        logic a, b;
        for (int i = 0; i < n; i++) do_tick(a, b);
    endtask

    task automatic run_vec(input logic [12:0] v);
        logic [2:0] code;
        logic self_m, oc, fc;
        int n_ofs, n_fs, n_rf;
        code = v[12:10]; slave_mode = v[9];
        n_ofs = int'(v[8:6]); n_fs = int'(v[5:3]); n_rf = int'(v[2:0]);
        self_m = (code == 3'b001);
        do_write(code);
        chk("R2 stored", {5'd0, mode_q}, {5'd0, code});
        chk("R2 pending drdy", {7'd0, drdy_n}, 8'd0);
        do_tick(oc, fc);
        slave_mode = ~slave_mode;
        chk("R3 drdy at start", {7'd0, drdy_n}, 8'd1);
        for (int i = 0; i < n_ofs; i++) begin
            chk(self_m ? "R4 sel" : "R7 sel", {6'd0, front_sel}, self_m ? 8'd1 : 8'd0);
            chk("R3 drdy ofs", {7'd0, drdy_n}, 8'd1);
            do_tick(oc, fc);
            chk(self_m ? "R4 ofs strobe" : "R7 ofs strobe", {6'd0, oc, fc}, (i == n_ofs - 1) ? 8'd2 : 8'd0);
        end
        for (int i = 0; i < n_fs; i++) begin
            chk(self_m ? "R5 sel" : "R7 sel", {6'd0, front_sel}, self_m ? 8'd2 : 8'd0);
            chk("R3 drdy fs", {7'd0, drdy_n}, 8'd1);
            do_tick(oc, fc);
            chk(self_m ? "R5 fs strobe" : "R7 fs strobe", {6'd0, oc, fc}, (i == n_fs - 1) ? 8'd1 : 8'd0);
        end
        chk(self_m ? "R6 mode cleared" : "R8 mode cleared", {5'd0, mode_q}, 8'd0);
        for (int i = 0; i < n_rf; i++) begin
            chk(self_m ? "R6 refill sel" : "R8 refill sel", {6'd0, front_sel}, 8'd0);
            data_valid = 1'b1;
            #1;
            chk(self_m ? "R6 refill drdy" : "R8 refill drdy", {7'd0, drdy_n}, 8'd1);
            do_tick(oc, fc);
        end
        chk(self_m ? "R6 drdy low" : "R8 drdy low", {7'd0, drdy_n}, 8'd0);
        slave_mode = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic oc, fc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 mode", {5'd0, mode_q}, 8'd0);
        chk("R1 sel", {6'd0, front_sel}, 8'd0);
        chk("R1 strobes", {6'd0, offset_capture, fullscale_capture}, 8'd0);
        chk("R1 drdy", {7'd0, drdy_n}, 8'd0);

        for (int k = 0; k < 6; k++) run_vec(VECS[k]);

        // R11 drdy follows data_valid in normal mode
        data_valid = 1'b0; #1;
        chk("R11 drdy invalid", {7'd0, drdy_n}, 8'd1);
        data_valid = 1'b1; #1;
        chk("R11 drdy valid", {7'd0, drdy_n}, 8'd0);

        // R10 reserved code acts as normal
        do_write(3'b101);
        chk("R10 readback", {5'd0, mode_q}, 8'd5);
        do_tick(oc, fc);
        chk("R10 drdy", {7'd0, drdy_n}, 8'd0);
        chk("R10 sel", {6'd0, front_sel}, 8'd0);
        chk("R10 strobes", {6'd0, oc, fc}, 8'd0);
        do_write(3'b000);

        // R9 write during routine ignored
        do_write(3'b001);
        do_tick(oc, fc);
        do_write(3'b000);
        chk("R9 ignored", {5'd0, mode_q}, 8'd1);
        do_write(3'b011);
        chk("R9 ignored 2", {5'd0, mode_q}, 8'd1);
        chk("R9 sel still short", {6'd0, front_sel}, 8'd1);
        ticks(9);
        chk("R9 end drdy", {7'd0, drdy_n}, 8'd0);

        // R9/R2 collision: pending code plus write on the start tick
        do_write(3'b010);
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = 3'b011; conv_tick = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0; conv_tick = 1'b0;
        chk("R9 collision mode", {5'd0, mode_q}, 8'd2);
        chk("R2 collision started", {7'd0, drdy_n}, 8'd1);
        do_tick(oc, fc); do_tick(oc, fc);
        chk("R7 no early strobe", {6'd0, oc, fc}, 8'd0);
        do_tick(oc, fc);
        chk("R7 offset strobe", {6'd0, oc, fc}, 8'd2);
        do_tick(oc, fc);
        chk("R8 one refill", {7'd0, drdy_n}, 8'd0);

        // R2 collision with normal field: stored, not started
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = 3'b001; conv_tick = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0; conv_tick = 1'b0;
        chk("R2 stored on tick", {5'd0, mode_q}, 8'd1);
        chk("R2 not started", {7'd0, drdy_n}, 8'd0);
        do_tick(oc, fc);
        chk("R2 started next", {7'd0, drdy_n}, 8'd1);
        ticks(9);
        chk("R6 end", {7'd0, drdy_n}, 8'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule